// File: doc/BRIEF.md
# Reference Fetch Request Controller

This block moves one macroblock's worth of reference pixels into local buffers ahead of a motion search. A fetch command gives the search range for this macroblock and the pixel position of the current block. The block works out a square window around that block: the block itself plus a margin of the search range on every side, clipped to the frame. It then asks an external memory controller for the bus, and after the controller grants the transfer it lists the window's 32-bit word addresses row by row. Each word carries four 8-bit pixels. The window grows and shrinks with the range chosen for each macroblock, so a small range costs proportionally fewer bus words.

The exchange with the memory controller always runs in the same order. First the block raises a request and holds it. The controller acknowledges when it is free. The block then streams the addresses, one word per cycle while the controller grants. Last, the controller reports finish. A per-row ready pulse lets the search engine start on rows that have already been fetched, and a done pulse marks the end of the fetch. A command that arrives while a fetch is running is kept and started after the current one finishes. A request that is never acknowledged is abandoned after a programmable number of cycles, and the block raises an error flag.

Top module: `ref_fetch_ctrl`

## Requirements
- R1: After reset, mem_req, mem_addr_valid, row_ready, fetch_done, fetch_err and busy are all low.
- R2: A command starts a fetch only while the block is idle; the fetch then raises mem_req, and mem_req stays high until mem_ack is sampled high.
- R3: No address is shown before mem_ack has been sampled. Each word address is cfg_base + row·(cfg_width/4) + column word. Addresses are issued row-major and advance by one word on each cycle that mem_grant is high. An address stays unchanged while mem_grant is low.
- R4: The window's columns run from max(x−SR,0) to min(x+15+SR, cfg_width−1) in pixels, widened to whole words (pixel column/4). Its rows run from max(y−SR,0) to min(y+15+SR, cfg_height−1). The block issues exactly rows × word-columns addresses and then no more. cfg_width is a multiple of 4.
- R5: row_ready pulses for one cycle, in the cycle after the last word of each row is granted, so the number of pulses equals the number of window rows.
- R6: After the last word, the block waits for mem_finish. fetch_done pulses for one cycle in the cycle after mem_finish is sampled, and the block returns to idle.
- R7: A command that arrives while busy is held and starts after the current fetch finishes, with its own parameters. A further command arriving before the held one starts replaces it.
- R8: If mem_ack is not sampled within cfg_ack_limit cycles of mem_req going high (cfg_ack_limit ≥ 1), mem_req drops, no address is issued and fetch_err goes high. fetch_err clears when the next fetch starts. An acknowledge in the last allowed cycle is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle fetch command strobe |
| cmd_sr | input | SR_W | Search range in pixels for this macroblock |
| cmd_x | input | CRD_W | Pixel column of the current block |
| cmd_y | input | CRD_W | Pixel row of the current block |
| cfg_width | input | CRD_W | Frame width in pixels (multiple of 4) |
| cfg_height | input | CRD_W | Frame height in pixels |
| cfg_base | input | ADDR_W | Word address of the frame's first word |
| cfg_ack_limit | input | LIM_W | Cycles allowed for acknowledge |
| mem_req | output | 1 | Transfer request to the memory controller |
| mem_ack | input | 1 | Acknowledge from the memory controller |
| mem_addr_valid | output | 1 | Word address phase active |
| mem_addr | output | ADDR_W | Word address |
| mem_grant | input | 1 | Controller takes the current address this cycle |
| mem_finish | input | 1 | Transfer complete |
| row_ready | output | 1 | One window row fully fetched |
| fetch_done | output | 1 | Fetch complete pulse |
| fetch_err | output | 1 | Acknowledge timeout flag |
| busy | output | 1 | Fetch running or command held |

## Verification
The bench checks windows at the top-left and bottom-right frame corners and a range larger than the whole frame. A design that clamps wrongly there would run addresses past the frame or skip edge rows. Unaligned window starts, from ranges that are not a multiple of four, would expose a design that forgets to round the first column down to a word. A grant that drops in random cycles would catch an address that moves without being taken. An acknowledge arriving in the very last allowed cycle, set against one that never arrives, separates an off-by-one timeout from a correct one. Back-to-back commands, including one that replaces a held one, catch a controller that loses, repeats or mixes up fetch parameters.

// File: rtl/ref_fetch_ctrl.sv
module ref_fetch_ctrl #(
  parameter int ADDR_W = 24,
  parameter int CRD_W  = 12,
  parameter int SR_W   = 6,
  parameter int LIM_W  = 12,
  parameter int BUS_W  = 32,
  parameter int PIX_W  = 8,
  parameter int MB_PIX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [SR_W-1:0]   cmd_sr,
  input  logic [CRD_W-1:0]  cmd_x,
  input  logic [CRD_W-1:0]  cmd_y,
  input  logic [CRD_W-1:0]  cfg_width,
  input  logic [CRD_W-1:0]  cfg_height,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LIM_W-1:0]  cfg_ack_limit,
  output logic              mem_req,
  input  logic              mem_ack,
  output logic              mem_addr_valid,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_grant,
  input  logic              mem_finish,
  output logic              row_ready,
  output logic              fetch_done,
  output logic              fetch_err,
  output logic              busy
);
  localparam int PPW   = BUS_W / PIX_W;
  localparam int WSH   = $clog2(PPW);
  localparam int EXT_W = CRD_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_ADDR, S_WAIT} state_t;
  state_t st_q;

  logic              pnd_v;
  logic [SR_W-1:0]   pnd_sr;
  logic [CRD_W-1:0]  pnd_x, pnd_y;

  logic [CRD_W-1:0]  col_q, col_first_q, col_last_q;
  logic [CRD_W-1:0]  row_q, row_last_q;
  logic [ADDR_W-1:0] row_base_q, stride_q;
  logic [LIM_W-1:0]  tmr_q;
  logic              rdy_q, done_q, err_q;

  function automatic logic [EXT_W-1:0] win_lo(input logic [CRD_W-1:0] c,
                                              input logic [SR_W-1:0] r);
    logic [EXT_W-1:0] ce, re;
    ce = {1'b0, c};
    re = EXT_W'(r);
    return (ce >= re) ? ce - re : '0;
  endfunction

  function automatic logic [EXT_W-1:0] win_hi(input logic [CRD_W-1:0] c,
                                              input logic [SR_W-1:0] r,
                                              input logic [CRD_W-1:0] size);
    logic [EXT_W-1:0] raw, lim;
    raw = {1'b0, c} + EXT_W'(r) + EXT_W'(MB_PIX - 1);
    lim = {1'b0, size} - EXT_W'(1);
    return (raw > lim) ? lim : raw;
  endfunction

  logic [EXT_W-1:0] lo_x, hi_x, lo_y, hi_y;
  logic [CRD_W-1:0] width_w;
  assign lo_x    = win_lo(pnd_x, pnd_sr);
  assign hi_x    = win_hi(pnd_x, pnd_sr, cfg_width);
  assign lo_y    = win_lo(pnd_y, pnd_sr);
  assign hi_y    = win_hi(pnd_y, pnd_sr, cfg_height);
  assign width_w = cfg_width >> WSH;

  wire start   = (st_q == S_IDLE) && pnd_v;
  wire row_end = (col_q == col_last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pnd_v  <= 1'b0;
      pnd_sr <= '0;
      pnd_x  <= '0;
      pnd_y  <= '0;
    end else if (cmd_valid) begin
      pnd_v  <= 1'b1;
      pnd_sr <= cmd_sr;
      pnd_x  <= cmd_x;
      pnd_y  <= cmd_y;
    end else if (start) begin
      pnd_v  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      col_q       <= '0;
      col_first_q <= '0;
      col_last_q  <= '0;
      row_q       <= '0;
      row_last_q  <= '0;
      row_base_q  <= '0;
      stride_q    <= '0;
      tmr_q       <= '0;
      rdy_q       <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      rdy_q  <= 1'b0;
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (pnd_v) begin
          col_q       <= CRD_W'(lo_x >> WSH);
          col_first_q <= CRD_W'(lo_x >> WSH);
          col_last_q  <= CRD_W'(hi_x >> WSH);
          row_q       <= CRD_W'(lo_y);
          row_last_q  <= CRD_W'(hi_y);
          row_base_q  <= cfg_base + ADDR_W'(lo_y) * ADDR_W'(width_w);
          stride_q    <= ADDR_W'(width_w);
          tmr_q       <= LIM_W'(1);
          err_q       <= 1'b0;
          st_q        <= S_REQ;
        end
        S_REQ: begin
          if (mem_ack) begin
            st_q <= S_ADDR;
          end else if (tmr_q >= cfg_ack_limit) begin
            err_q <= 1'b1;
            st_q  <= S_IDLE;
          end else begin
            tmr_q <= tmr_q + LIM_W'(1);
          end
        end
        S_ADDR: if (mem_grant) begin
          if (row_end) begin
            col_q      <= col_first_q;
            row_base_q <= row_base_q + stride_q;
            rdy_q      <= 1'b1;
            if (row_q == row_last_q) st_q <= S_WAIT;
            else                     row_q <= row_q + CRD_W'(1);
          end else begin
            col_q <= col_q + CRD_W'(1);
          end
        end
        S_WAIT: if (mem_finish) begin
          st_q   <= S_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req        = (st_q == S_REQ);
  assign mem_addr_valid = (st_q == S_ADDR);
  assign mem_addr       = row_base_q + ADDR_W'(col_q);
  assign row_ready      = rdy_q;
  assign fetch_done     = done_q;
  assign fetch_err      = err_q;
  assign busy           = (st_q != S_IDLE) || pnd_v;
endmodule

// File: rtl/ref_fetch_ctrl_chk.sv
module ref_fetch_ctrl_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_addr_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_grant,
  input logic              mem_finish,
  input logic              row_ready,
  input logic              fetch_done,
  input logic              fetch_err
);
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req || fetch_err);

  a_r3_addr_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_addr_valid) |-> $past(mem_ack));

  a_r3_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_addr_valid));

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr_valid && !mem_grant |=> mem_addr_valid && $stable(mem_addr));

  a_r5_row_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    row_ready |-> $past(mem_addr_valid && mem_grant));

  a_r6_done_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |-> $past(mem_finish));

  a_r8_err_on_missing_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_err) |-> $past(mem_req && !mem_ack));
endmodule

bind ref_fetch_ctrl ref_fetch_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr_valid(mem_addr_valid), .mem_addr(mem_addr), .mem_grant(mem_grant),
  .mem_finish(mem_finish), .row_ready(row_ready), .fetch_done(fetch_done),
  .fetch_err(fetch_err)
);

// File: tb/ref_fetch_ctrl_bench.sv
module ref_fetch_ctrl_bench;
  localparam int ADDR_W = 24, CRD_W = 12, SR_W = 6, LIM_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              cmd_valid = 1'b0;
  logic [SR_W-1:0]   cmd_sr = '0;
  logic [CRD_W-1:0]  cmd_x = '0, cmd_y = '0;
  logic [CRD_W-1:0]  cfg_width, cfg_height;
  logic [ADDR_W-1:0] cfg_base;
  logic [LIM_W-1:0]  cfg_ack_limit;
  logic mem_req, mem_addr_valid, row_ready, fetch_done, fetch_err, busy;
  logic mem_ack = 1'b0, mem_grant = 1'b0, mem_finish = 1'b0;
  logic [ADDR_W-1:0] mem_addr;

  int width = 128, height = 96, base = 4096, limit = 20;
  assign cfg_width     = width[CRD_W-1:0];
  assign cfg_height    = height[CRD_W-1:0];
  assign cfg_base      = base[ADDR_W-1:0];
  assign cfg_ack_limit = limit[LIM_W-1:0];

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  ref_fetch_ctrl u_ref_fetch_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sr(cmd_sr),
    .cmd_x(cmd_x), .cmd_y(cmd_y), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_base(cfg_base), .cfg_ack_limit(cfg_ack_limit), .mem_req(mem_req),
    .mem_ack(mem_ack), .mem_addr_valid(mem_addr_valid), .mem_addr(mem_addr),
    .mem_grant(mem_grant), .mem_finish(mem_finish), .row_ready(row_ready),
    .fetch_done(fetch_done), .fetch_err(fetch_err), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lo_of(input int c, input int r);
    return (c >= r) ? c - r : 0;
  endfunction

  function automatic int hi_of(input int c, input int r, input int size);
    int h;
    h = c + 15 + r;
    return (h > size - 1) ? size - 1 : h;
  endfunction

  task automatic send_cmd(input int sr, input int x, input int y);
    cmd_valid = 1'b1;
    cmd_sr = sr[SR_W-1:0];
    cmd_x = x[CRD_W-1:0];
    cmd_y = y[CRD_W-1:0];
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic serve(input int sr, input int x, input int y, input int ack_dly);
    int x0w, x1w, y0, y1, cols, rows, ww, k, rows_seen, guard, extra;
    bit prev_hold;
    logic [ADDR_W-1:0] prev_addr;
    x0w = lo_of(x, sr) / 4;
    x1w = hi_of(x, sr, width) / 4;
    y0 = lo_of(y, sr);
    y1 = hi_of(y, sr, height);
    cols = x1w - x0w + 1;
    rows = y1 - y0 + 1;
    ww = width / 4;
    k = 0; rows_seen = 0; guard = 0;
    prev_hold = 1'b0; prev_addr = '0;
    while (!mem_req && guard < 40) begin @(negedge clk); guard++; end
    chk(mem_req, "R2 request raised for command", int'(mem_req), 1);
    chk(!fetch_err, "R8 error cleared at fetch start", int'(fetch_err), 0);
    for (int i = 0; i < ack_dly; i++) begin
      chk(mem_req && !mem_addr_valid, "R2 request held without address before ack",
          int'({mem_req, mem_addr_valid}), 2);
      @(negedge clk);
    end
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    guard = 0;
    while (k < rows * cols && guard < 20000) begin
      rows_seen += int'(row_ready);
      if (rows_seen > k / cols) chk(1'b0, "R5 row ready before row complete", rows_seen, k / cols);
      if (prev_hold) chk(mem_addr == prev_addr, "R3 address held while grant low",
                         int'(mem_addr), int'(prev_addr));
      if (!mem_addr_valid) begin
        chk(1'b0, "R3 address phase active during fetch", 0, 1);
      end else begin
        bit g;
        g = ($urandom % 4) != 0;
        mem_grant = g;
        if (g) begin
          int ea;
          ea = base + (y0 + k / cols) * ww + x0w + k % cols;
          chk(int'(mem_addr) == ea, "R3 word address", int'(mem_addr), ea);
          k++;
          prev_hold = 1'b0;
        end else begin
          prev_hold = 1'b1;
          prev_addr = mem_addr;
        end
      end
      @(negedge clk);
      guard++;
    end
    mem_grant = 1'b0;
    extra = 1 + int'($urandom % 4);
    for (int i = 0; i < extra; i++) begin
      rows_seen += int'(row_ready);
      chk(!mem_addr_valid, "R4 no words beyond window", int'(mem_addr_valid), 0);
      @(negedge clk);
    end
    mem_finish = 1'b1;
    @(negedge clk);
    mem_finish = 1'b0;
    chk(fetch_done, "R6 done pulse after finish", int'(fetch_done), 1);
    chk(rows_seen == rows, "R5 row ready count", rows_seen, rows);
    chk(k == rows * cols, "R4 words issued", k, rows * cols);
    @(negedge clk);
    chk(!fetch_done, "R6 done lasts one cycle", int'(fetch_done), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !mem_addr_valid, "R1 reset bus outputs", int'({mem_req, mem_addr_valid}), 0);
    chk(!row_ready && !fetch_done, "R1 reset pulses", int'({row_ready, fetch_done}), 0);
    chk(!fetch_err && !busy, "R1 reset status", int'({fetch_err, busy}), 0);

    send_cmd(0, 48, 32);   serve(0, 48, 32, 0);
    chk(!busy, "R6 idle after finish", int'(busy), 0);
    send_cmd(8, 0, 0);     serve(8, 0, 0, 3);
    send_cmd(7, 112, 80);  serve(7, 112, 80, 1);
    width = 64; height = 48;
    send_cmd(63, 16, 16);  serve(63, 16, 16, 2);
    width = 128; height = 96;

    limit = 6;
    send_cmd(5, 32, 32);   serve(5, 32, 32, 5);

    limit = 5;
    send_cmd(4, 32, 32);
    begin
      int n, g;
      n = 0; g = 0;
      while (!mem_req && g < 40) begin @(negedge clk); g++; end
      while (mem_req && n < 100) begin
        if (mem_addr_valid) chk(1'b0, "R8 no address without ack", 1, 0);
        n++;
        @(negedge clk);
      end
      chk(n == 5, "R8 request length before timeout", n, 5);
      chk(fetch_err, "R8 error flag raised", int'(fetch_err), 1);
      chk(!mem_addr_valid && !busy, "R8 back to idle", int'({mem_addr_valid, busy}), 0);
    end
    limit = 20;
    send_cmd(2, 64, 16);   serve(2, 64, 16, 0);

    send_cmd(3, 16, 16);
    send_cmd(9, 80, 48);
    serve(3, 16, 16, 1);
    serve(9, 80, 48, 2);
    chk(!busy, "R7 idle after held command ran", int'(busy), 0);

    send_cmd(1, 0, 32);
    send_cmd(6, 32, 0);
    send_cmd(10, 96, 64);
    serve(1, 0, 32, 0);
    serve(10, 96, 64, 4);
    repeat (3) @(negedge clk);
    chk(!mem_req && !busy, "R7 replaced command not run", int'({mem_req, busy}), 0);

    for (int t = 0; t < 30; t++) begin
      int sr, x, y, d;
      width  = 16 * (4 + int'($urandom % 17));
      height = 16 * (3 + int'($urandom % 10));
      base   = int'($urandom % 65536);
      sr = int'($urandom % 25);
      x  = 16 * int'($urandom % (width / 16));
      y  = 16 * int'($urandom % (height / 16));
      d  = int'($urandom % 8);
      send_cmd(sr, x, y);
      serve(sr, x, y, d);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule